// File: doc/BRIEF.md
# Edge-Triggered Interrupt Event Controller

This block collects asynchronous request lines from pins and peripherals and turns them into interrupt requests, single-cycle event pulses and one combined wake-up request. Every line is first brought into the clock domain through a two-flop synchroniser.

There are two classes of line. Configurable lines (0 to NC-1, default 26) detect a rising edge, a falling edge or both, as chosen by two independent enable bits. A detected edge latches a pending flag, which software clears by writing 1 to it. Software can also raise a request on such a line through a trigger register. Direct lines (NC to NC+ND-1, default 14) carry a peripheral's level request straight through. They have no pending flag, and only their two mask bits gate them.

Register map (`addr`, every bit i means line i): 0 interrupt mask, 1 event mask, 2 rising-edge enable, 3 falling-edge enable, 4 software trigger, 5 pending. Registers 2, 3, 4 and 5 exist only for configurable lines and read 0 in the direct-line positions. All other addresses read 0. Reads are combinational from `addr`. A write takes effect at the clock edge where `wr_en` is high.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the interrupt mask (addr 0) reads 1 in the direct-line bits and 0 in the configurable bits. Addresses 1 to 5 read 0.
- R2: A rising edge on a configurable line whose rising enable (addr 2) is 1 sets its pending bit (addr 5) 3 clocks after the input changes.
- R3: A falling edge sets the pending bit when the falling enable (addr 3) is 1. With both enables set, either edge sets it.
- R4: An edge whose enable bit is 0 leaves the pending bit and the outputs unchanged.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: Writing 1 to a software-trigger bit (addr 4) sets that line's pending bit and its trigger bit at the next clock, whatever the edge enables are. The trigger bit clears when its pending bit is cleared.
- R7: A configurable line's `evt_o` bit is a one-cycle pulse for each detected edge or software trigger, gated by the event mask (addr 1).
- R8: A configurable line's `irq_o` bit is high exactly while its pending bit and its interrupt mask bit are both 1. Clearing the mask bit drops the interrupt but keeps the pending bit.
- R9: For a direct line, `irq_o` and `evt_o` equal the synchronised input ANDed with the interrupt mask or the event mask. The line never sets a pending bit.
- R10: `wake_o` is high whenever any bit of `irq_o` or `evt_o` is high.
- R11: When a detected edge and a write-1-to-clear reach the same pending bit in the same cycle, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_req | input | NC+ND | Asynchronous request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | NC+ND | Write data, one bit per line |
| rdata | output | NC+ND | Read data for `addr` |
| irq_o | output | NC+ND | Interrupt requests per line |
| evt_o | output | NC+ND | Event requests per line |
| wake_o | output | 1 | Wake-up request |

## Verification
An input change driven at a falling edge reaches the pending bits, `irq_o` and the event pulse after the third rising edge. A direct line's level shows after the second rising edge. The bench therefore waits three rising edges after each input change and samples at the next falling edge. It samples again one cycle later to confirm that the event pulse has ended. A software-trigger write is checked at the falling edge right after the rising edge that captures it, which is where its event pulse and pending bit first appear. For the same-cycle set-and-clear case, the clear write is placed in the cycle where the edge is still being detected.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NC = 26,
  parameter int ND = 14,
  localparam int NL = NC + ND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] hw_req,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [NL-1:0] wdata,
  output logic [NL-1:0] rdata,
  output logic [NL-1:0] irq_o,
  output logic [NL-1:0] evt_o,
  output logic          wake_o
);
  localparam logic [2:0] A_IMSK = 3'd0, A_EMSK = 3'd1, A_RISE = 3'd2,
                         A_FALL = 3'd3, A_SWT = 3'd4, A_PEND = 3'd5;

  logic [NL-1:0] s1, s2, imask, emask;
  logic [NC-1:0] lvl_q, rise, fall, swt, pend, trig_q;

  wire [NC-1:0] cur    = s2[NC-1:0];
  wire [NC-1:0] hit    = (cur & ~lvl_q & rise) | (~cur & lvl_q & fall);
  wire          wr_swt = wr_en && addr == A_SWT;
  wire          wr_pnd = wr_en && addr == A_PEND;
  wire [NC-1:0] sw_set = wr_swt ? wdata[NC-1:0] : '0;
  wire [NC-1:0] clr    = wr_pnd ? wdata[NC-1:0] : '0;
  wire [NC-1:0] set    = hit | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      lvl_q  <= '0;
      imask  <= {{ND{1'b1}}, {NC{1'b0}}};
      emask  <= '0;
      rise   <= '0;
      fall   <= '0;
      swt    <= '0;
      pend   <= '0;
      trig_q <= '0;
    end else begin
      s1     <= hw_req;
      s2     <= s1;
      lvl_q  <= cur;
      pend   <= (pend & ~clr) | set;
      swt    <= (swt & ~clr) | sw_set;
      trig_q <= set;
      if (wr_en && addr == A_IMSK) imask <= wdata;
      if (wr_en && addr == A_EMSK) emask <= wdata;
      if (wr_en && addr == A_RISE) rise  <= wdata[NC-1:0];
      if (wr_en && addr == A_FALL) fall  <= wdata[NC-1:0];
    end
  end

  always_comb begin
    case (addr)
      A_IMSK:  rdata = imask;
      A_EMSK:  rdata = emask;
      A_RISE:  rdata = {{ND{1'b0}}, rise};
      A_FALL:  rdata = {{ND{1'b0}}, fall};
      A_SWT:   rdata = {{ND{1'b0}}, swt};
      A_PEND:  rdata = {{ND{1'b0}}, pend};
      default: rdata = '0;
    endcase
  end

  assign irq_o  = {s2[NL-1:NC] & imask[NL-1:NC], pend & imask[NC-1:0]};
  assign evt_o  = {s2[NL-1:NC] & emask[NL-1:NC], trig_q & emask[NC-1:0]};
  assign wake_o = |irq_o || |evt_o;

  a_r2_edge_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    |hit |=> (pend & $past(hit)) == $past(hit));

  a_r6_sw_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    wr_swt |=> (pend & $past(wdata[NC-1:0])) == $past(wdata[NC-1:0]));

  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pnd |=> (pend & $past(clr & ~set)) == '0);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr & set) |=> (pend & $past(clr & set)) == $past(clr & set));

  a_r6_trig_within_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (swt & ~pend) == '0);

  a_r4_pend_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(set)) == '0);
endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
  localparam int NC = 26, ND = 14, NL = NC + ND;
  localparam time TCLK = 10ns;
  localparam logic [NL-1:0] CFG = {{ND{1'b0}}, {NC{1'b1}}};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [NL-1:0] hw_req = '0, wdata = '0, rdata, irq_o, evt_o;
  logic wake_o;

  edge_irq_ctrl #(.NC(NC), .ND(ND)) u0 (.clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .evt_o(evt_o), .wake_o(wake_o));

  always #(TCLK/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NL-1:0] m_hw = '0, m_im = {{ND{1'b1}}, {NC{1'b0}}}, m_em = '0;
  logic [NL-1:0] m_rise = '0, m_fall = '0, m_swt = '0, m_pend = '0;

  task automatic chk(string tag, logic [NL-1:0] got, logic [NL-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_irq();
    return (m_pend & m_im & CFG) | (m_hw & m_im & ~CFG);
  endfunction

  task automatic rd(logic [2:0] a, output logic [NL-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wreg(logic [2:0] a, logic [NL-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    case (a)
      3'd0: m_im = d;
      3'd1: m_em = d;
      3'd2: m_rise = d & CFG;
      3'd3: m_fall = d & CFG;
      3'd4: begin m_pend |= d & CFG; m_swt |= d & CFG; end
      3'd5: begin m_pend &= ~d; m_swt &= ~d; end
      default: ;
    endcase
  endtask

  function automatic logic [NL-1:0] edges_of(logic [NL-1:0] nw);
    return ((nw & ~m_hw & m_rise) | (~nw & m_hw & m_fall)) & CFG;
  endfunction

  task automatic step(logic [NL-1:0] nw, string tag);
    logic [NL-1:0] e, v;
    e = edges_of(nw);
    m_pend |= e;
    @(negedge clk); hw_req = nw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_hw = nw;
    chk({tag, " R7 evt pulse"}, evt_o, (e & m_em) | (nw & m_em & ~CFG));
    chk({tag, " R8/R9 irq"}, irq_o, exp_irq());
    chk({tag, " R10 wake"}, {{(NL-1){1'b0}}, wake_o},
        {{(NL-1){1'b0}}, (|exp_irq()) || (|((e | (nw & ~CFG)) & m_em))});
    rd(3'd5, v);
    chk({tag, " R2/R3/R4 pend"}, v, m_pend);
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, evt_o, nw & m_em & ~CFG);
  endtask

  initial begin
    logic [NL-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(3'd0, v); chk("R1 imask reset", v, {{ND{1'b1}}, {NC{1'b0}}});
    for (int a = 1; a < 6; a++) begin
      rd(a[2:0], v); chk("R1 reg reset", v, '0);
    end
    chk("R1 outputs idle", irq_o | evt_o, '0);

    wreg(3'd2, 40'h5);
    wreg(3'd3, 40'h6);
    wreg(3'd0, '1);
    wreg(3'd1, '1);
    step(40'h1, "R2 rise line0");
    step(40'h3, "R4 rise line1 disabled");
    step(40'h0, "R3 fall line1");
    step(40'h4, "R3 both line2 rise");
    wreg(3'd5, 40'h4);
    step(40'h0, "R3 both line2 fall");
    wreg(3'd5, 40'h0);
    rd(3'd5, v); chk("R5 write 0 no effect", v, m_pend);
    wreg(3'd5, 40'h7);
    rd(3'd5, v); chk("R5 w1c", v, 40'h0);
    step(40'h1 << 30, "R9 direct line high");
    step(40'h0, "R9 direct line low");
    wreg(3'd0, ~(40'h1 << 30));
    step(40'h1 << 30, "R9 direct masked");

    // R6 software trigger on line 3 (no edge enables)
    @(negedge clk); wr_en = 1; addr = 3'd4; wdata = 40'h8;
    @(negedge clk); wr_en = 0; m_pend |= 40'h8; m_swt |= 40'h8;
    chk("R6/R7 sw evt pulse", evt_o & CFG, 40'h8);
    rd(3'd5, v); chk("R6 sw sets pend", v, m_pend);
    rd(3'd4, v); chk("R6 sw bit set", v, 40'h8);
    @(negedge clk); chk("R7 sw pulse ends", evt_o & CFG, 40'h0);
    // R8 mask off keeps pend
    wreg(3'd0, m_im & ~40'h8);
    chk("R8 irq drops with mask", irq_o & 40'h8, 40'h0);
    rd(3'd5, v); chk("R8 pend kept", v & 40'h8, 40'h8);
    wreg(3'd5, 40'h8);
    rd(3'd4, v); chk("R6 sw bit clears with pend", v, 40'h0);

    // R11 edge and clear in same cycle on line 0 (pend0 set first)
    wreg(3'd4, 40'h1);
    m_pend |= 40'h1;
    @(negedge clk); hw_req = m_hw ^ 40'h1;
    if (!m_hw[0]) begin
      repeat (2) @(posedge clk);
      @(negedge clk); wr_en = 1; addr = 3'd5; wdata = 40'h1;
      @(negedge clk); wr_en = 0;
      m_hw = hw_req; m_swt &= ~40'h1;
      rd(3'd5, v); chk("R11 set wins", v & 40'h1, 40'h1);
    end else begin
      repeat (3) @(posedge clk); @(negedge clk); m_hw = hw_req;
      chk("R11 setup line0 low", m_hw & 40'h1, 40'h0);
    end
    rd(3'd4, v); chk("R11 sw bit cleared", v, m_swt);

    for (int i = 0; i < 150; i++) begin
      int r;
      r = $urandom % 7;
      if (r < 4) wreg(r[2:0], {$urandom, $urandom});
      else if (r == 4) wreg(3'd5, {$urandom, $urandom});
      else if (r == 5) wreg(3'd4, {$urandom, $urandom} & {$urandom, $urandom});
      step({$urandom, $urandom}, "rand");
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule